// File: doc/BRIEF.md
# Perfect-Match Receive Address Filter

This block decides whether an incoming Ethernet frame is accepted, using the frame's 48-bit destination address. It keeps a table of perfect-match addresses, sixteen by default. Software fills the table by sending a setup frame through a byte stream. A start pulse gives the frame length, and each byte that follows is qualified by a valid strobe. Each entry sits in its own 12-byte slot of the setup frame and uses only six bytes of that slot.

A compare request latches a destination address and four mode flags: promiscuous, receive-all, pass-all-multicast and inverse filtering. The block then walks the table one entry per clock and stops at the first hit. It raises a one-cycle done pulse with the accept decision and two descriptor status flags. One flag reports that filtering failed and the frame was taken anyway. The other reports that the frame was taken as a multicast frame.

A request that arrives while a setup frame is streaming waits until the load has finished. It is then judged against the new table.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset every table entry is all zeros and `done_o`, `accept_o`, `filt_fail_o` and `mcast_o` are low, so a compare of address 0 hits entry 0.
- R2: A setup frame changes the table only when its length is exactly N_ENTRIES*12 bytes (192 by default). With any other length, such as 191 or 193, the table stays as it was.
- R3: Entry n takes its address bytes 0..5 from setup-frame offsets 12n+0, 12n+1, 12n+4, 12n+5, 12n+8 and 12n+9, in that order, and ignores the other six bytes of the slot. Address byte 0 is `cmp_addr_i[47:40]` and byte 5 is `cmp_addr_i[7:0]`.
- R4: The all-ones address is always accepted with both status flags low, whatever the mode flags, inverse filtering included.
- R5: For any other address, if `promisc_i` or `rx_all_i` is set, the frame is accepted and `filt_fail_o` is raised. This rule outranks pass-all-multicast.
- R6: Otherwise, if `pass_mcast_i` is set and `cmp_addr_i[40]` (bit 0 of byte 0) is 1, the frame is accepted and `mcast_o` is raised.
- R7: Otherwise `accept_o` equals (hit on any entry) XOR `inverse_i`, and both flags are low.
- R8: A compare request made during a setup load is held until the last byte of the load. It is then evaluated against the updated table.
- R9: `done_o` is a single-cycle pulse. When the first hit is at entry k it comes k+1 clock edges after the edge that accepts the request, and after N_ENTRIES edges when there is no hit. The results hold until the next done.
- R10: A request that arrives while a compare is waiting or scanning is ignored and does not disturb that compare's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_start_i | input | 1 | Starts a setup frame; the length is sampled in the same cycle |
| setup_len_i | input | LEN_W | Setup frame length in bytes |
| setup_valid_i | input | 1 | Setup byte valid strobe |
| setup_byte_i | input | 8 | Setup frame byte |
| cmp_req_i | input | 1 | Compare request pulse |
| cmp_addr_i | input | 48 | Destination address; byte 0 is in [47:40] |
| promisc_i | input | 1 | Promiscuous mode |
| rx_all_i | input | 1 | Receive-all mode |
| pass_mcast_i | input | 1 | Pass all multicast frames |
| inverse_i | input | 1 | Invert the perfect-match result |
| done_o | output | 1 | One-cycle compare done pulse |
| accept_o | output | 1 | Frame accepted |
| filt_fail_o | output | 1 | Filtering-failed status flag |
| mcast_o | output | 1 | Multicast status flag |

## Verification
The bench builds the block with its default parameters: sixteen entries, a 192-byte setup frame and a 12-bit length. These values make it possible to reach a hit on the last entry at the full scan latency and a complete miss scan. They also allow off-by-one setup lengths of 191 and 193 to be tried against a table filled with known contents. Random setup frames and random addresses drawn from the table, from broadcast and from noise are mixed with random mode flags. The bench also directs a request made mid-load and a request made mid-scan.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int SLOT_BYTES = 12;
  localparam int MAC_W      = ADDR_BYTES * 8;

  typedef logic [MAC_W-1:0] mac_t;

  typedef enum logic [1:0] {
    CMP_IDLE = 2'd0,
    CMP_WAIT = 2'd1,
    CMP_SCAN = 2'd2
  } cmp_state_e;

  // Slot position -> address byte: kept when pos[1]==0, index = pos[3:2]*2 + pos[0]
  function automatic logic slot_keep(input logic [3:0] pos);
    return (pos[1] == 1'b0) && (pos < 4'(SLOT_BYTES));
  endfunction

  function automatic logic [2:0] slot_byte_idx(input logic [3:0] pos);
    return {pos[3:2], pos[0]};
  endfunction
endpackage

// File: rtl/filt_setup_load.sv
module filt_setup_load
  import rx_filt_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int LEN_W     = 12,
  parameter int SETUP_LEN = N_ENTRIES * SLOT_BYTES
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        setup_start_i,
  input  logic [LEN_W-1:0]            setup_len_i,
  input  logic                        setup_valid_i,
  input  logic [7:0]                  setup_byte_i,
  output logic                        busy_o,
  output logic [N_ENTRIES-1:0][MAC_W-1:0] table_o
);
  localparam int SLOT_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic             busy_q, len_ok_q;
  logic [LEN_W-1:0] rem_q;
  logic [SLOT_W-1:0] slot_q;
  logic [3:0]       pos_q;
  logic             take, wr_en;
  logic [2:0]       byte_idx;

  assign take     = setup_valid_i && busy_q && !setup_start_i;
  assign wr_en    = take && len_ok_q && slot_keep(pos_q);
  assign byte_idx = slot_byte_idx(pos_q);
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      len_ok_q <= 1'b0;
      rem_q    <= '0;
      slot_q   <= '0;
      pos_q    <= '0;
    end else if (setup_start_i) begin
      busy_q   <= (setup_len_i != '0);
      len_ok_q <= (setup_len_i == LEN_W'(SETUP_LEN));
      rem_q    <= setup_len_i;
      slot_q   <= '0;
      pos_q    <= '0;
    end else if (take) begin
      rem_q <= rem_q - LEN_W'(1);
      if (rem_q == LEN_W'(1)) busy_q <= 1'b0;
      if (pos_q == 4'(SLOT_BYTES - 1)) begin
        pos_q  <= '0;
        slot_q <= slot_q + SLOT_W'(1);
      end else begin
        pos_q <= pos_q + 4'd1;
      end
    end
  end

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    mac_t entry_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entry_q <= '0;
      end else if (wr_en && slot_q == SLOT_W'(g)) begin
        entry_q[(ADDR_BYTES - 1 - int'(byte_idx)) * 8 +: 8] <= setup_byte_i;
      end
    end
    assign table_o[g] = entry_q;
  end

  // R2
  len_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !len_ok_q |=> $stable(table_o));

  // R8
  load_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && setup_valid_i && !setup_start_i && rem_q == LEN_W'(1)) |=> !busy_q);
endmodule

// File: rtl/filt_compare_seq.sv
module filt_compare_seq
  import rx_filt_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_ENTRIES-1:0][MAC_W-1:0] table_i,
  input  logic                            load_busy_i,
  input  logic                            req_i,
  input  mac_t                            addr_i,
  input  logic                            promisc_i,
  input  logic                            rx_all_i,
  input  logic                            pass_mcast_i,
  input  logic                            inverse_i,
  output logic                            done_o,
  output logic                            accept_o,
  output logic                            filt_fail_o,
  output logic                            mcast_o
);
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  cmp_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  mac_t             addr_q;
  logic             prom_q, mc_q, inv_q;
  logic             done_q, acc_q, ff_q, mf_q;
  logic             hit, last, acc_d, ff_d, mf_d;

  assign hit  = (table_i[idx_q] == addr_q);
  assign last = (idx_q == IDX_W'(N_ENTRIES - 1));

  // Fixed priority: broadcast, promiscuous/receive-all, multicast, perfect match
  always_comb begin
    acc_d = hit ^ inv_q;
    ff_d  = 1'b0;
    mf_d  = 1'b0;
    if (&addr_q) begin
      acc_d = 1'b1;
    end else if (prom_q) begin
      acc_d = 1'b1;
      ff_d  = 1'b1;
    end else if (mc_q && addr_q[MAC_W-8]) begin
      acc_d = 1'b1;
      mf_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CMP_IDLE;
      idx_q   <= '0;
      addr_q  <= '0;
      prom_q  <= 1'b0;
      mc_q    <= 1'b0;
      inv_q   <= 1'b0;
      done_q  <= 1'b0;
      acc_q   <= 1'b0;
      ff_q    <= 1'b0;
      mf_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        CMP_IDLE: if (req_i) begin
          addr_q  <= addr_i;
          prom_q  <= promisc_i | rx_all_i;
          mc_q    <= pass_mcast_i;
          inv_q   <= inverse_i;
          idx_q   <= '0;
          state_q <= load_busy_i ? CMP_WAIT : CMP_SCAN;
        end
        CMP_WAIT: if (!load_busy_i) state_q <= CMP_SCAN;
        CMP_SCAN: begin
          if (hit || last) begin
            state_q <= CMP_IDLE;
            done_q  <= 1'b1;
            acc_q   <= acc_d;
            ff_q    <= ff_d;
            mf_q    <= mf_d;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: state_q <= CMP_IDLE;
      endcase
    end
  end

  assign done_o      = done_q;
  assign accept_o    = acc_q;
  assign filt_fail_o = ff_q;
  assign mcast_o     = mf_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R8
  hold_in_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CMP_WAIT && load_busy_i) |=> (state_q == CMP_WAIT));

  // R4
  bcast_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && (&addr_q)) |-> (acc_q && !ff_q && !mf_q));

  // R5
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !(ff_q && mf_q));

  // R6
  flag_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && (ff_q || mf_q)) |-> acc_q);

  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != CMP_IDLE && !done_q) |=> $stable(addr_q));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_filt_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int LEN_W     = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             setup_start_i,
  input  logic [LEN_W-1:0] setup_len_i,
  input  logic             setup_valid_i,
  input  logic [7:0]       setup_byte_i,
  input  logic             cmp_req_i,
  input  logic [47:0]      cmp_addr_i,
  input  logic             promisc_i,
  input  logic             rx_all_i,
  input  logic             pass_mcast_i,
  input  logic             inverse_i,
  output logic             done_o,
  output logic             accept_o,
  output logic             filt_fail_o,
  output logic             mcast_o
);
  localparam int SETUP_LEN = N_ENTRIES * SLOT_BYTES;

  logic                            load_busy;
  logic [N_ENTRIES-1:0][MAC_W-1:0] table_w;

  filt_setup_load #(
    .N_ENTRIES (N_ENTRIES),
    .LEN_W     (LEN_W),
    .SETUP_LEN (SETUP_LEN)
  ) u_load (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .setup_start_i (setup_start_i),
    .setup_len_i   (setup_len_i),
    .setup_valid_i (setup_valid_i),
    .setup_byte_i  (setup_byte_i),
    .busy_o        (load_busy),
    .table_o       (table_w)
  );

  filt_compare_seq #(
    .N_ENTRIES (N_ENTRIES)
  ) u_cmp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .table_i      (table_w),
    .load_busy_i  (load_busy),
    .req_i        (cmp_req_i),
    .addr_i       (cmp_addr_i),
    .promisc_i    (promisc_i),
    .rx_all_i     (rx_all_i),
    .pass_mcast_i (pass_mcast_i),
    .inverse_i    (inverse_i),
    .done_o       (done_o),
    .accept_o     (accept_o),
    .filt_fail_o  (filt_fail_o),
    .mcast_o      (mcast_o)
  );
endmodule

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;
  localparam int N     = 16;
  localparam int LEN_W = 12;
  localparam int FLEN  = N * 12;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             setup_start_i = 1'b0;
  logic [LEN_W-1:0] setup_len_i = '0;
  logic             setup_valid_i = 1'b0;
  logic [7:0]       setup_byte_i = '0;
  logic             cmp_req_i = 1'b0;
  logic [47:0]      cmp_addr_i = '0;
  logic             promisc_i = 1'b0, rx_all_i = 1'b0, pass_mcast_i = 1'b0, inverse_i = 1'b0;
  logic             done_o, accept_o, filt_fail_o, mcast_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  logic [47:0] mt [N];
  logic [7:0]  frm [256];

  rx_addr_filter #(.N_ENTRIES(N), .LEN_W(LEN_W)) dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int slot_off(input int j);
    return (j / 2) * 4 + (j % 2);
  endfunction

  function automatic logic [47:0] frm_addr(input int n, input int shift);
    logic [47:0] a;
    for (int j = 0; j < 6; j++) a[47-8*j -: 8] = frm[12*n + slot_off(j) + shift];
    return a;
  endfunction

  task automatic model(input logic [47:0] a, input bit p, input bit ra, input bit pm, input bit inv,
                       output bit acc, output bit ff, output bit mf, output int lat);
    int k = -1;
    for (int i = 0; i < N; i++) if (k < 0 && mt[i] == a) k = i;
    lat = (k >= 0) ? k + 1 : N;
    ff = 0; mf = 0;
    if (&a) acc = 1;
    else if (p || ra) begin acc = 1; ff = 1; end
    else if (pm && a[40]) begin acc = 1; mf = 1; end
    else acc = (k >= 0) ^ inv;
  endtask

  task automatic rand_frame();
    for (int i = 0; i < 256; i++) frm[i] = 8'($urandom);
  endtask

  task automatic do_load(input int len);
    @(negedge clk_i);
    setup_start_i = 1; setup_len_i = LEN_W'(len);
    @(negedge clk_i);
    setup_start_i = 0;
    for (int i = 0; i < len; i++) begin
      setup_valid_i = 1; setup_byte_i = frm[i];
      @(negedge clk_i);
    end
    setup_valid_i = 0;
    if (len == FLEN) for (int n = 0; n < N; n++) mt[n] = frm_addr(n, 0);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(posedge clk_i); n++;
      @(negedge clk_i);
    end while (!done_o && n < 60);
  endtask

  task automatic cmp_check(input string req, input logic [47:0] a,
                           input bit p, input bit ra, input bit pm, input bit inv);
    bit e_acc, e_ff, e_mf; int e_lat, n;
    model(a, p, ra, pm, inv, e_acc, e_ff, e_mf, e_lat);
    @(negedge clk_i);
    cmp_req_i = 1; cmp_addr_i = a; promisc_i = p; rx_all_i = ra; pass_mcast_i = pm; inverse_i = inv;
    @(posedge clk_i);
    @(negedge clk_i);
    cmp_req_i = 0;
    wait_done(n);
    chk({req, " accept"}, 64'(accept_o), 64'(e_acc));
    chk({req, " filt_fail"}, 64'(filt_fail_o), 64'(e_ff));
    chk({req, " mcast"}, 64'(mcast_o), 64'(e_mf));
    chk({req, " latency R9"}, 64'(n), 64'(e_lat));
    @(posedge clk_i); @(negedge clk_i);
    chk("R9 done one cycle", 64'(done_o), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit e_acc, e_ff, e_mf; int e_lat, n; bit early;
    logic [47:0] a, a2;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) mt[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1: outputs after reset
    chk("R1 done", 64'(done_o), 0);
    chk("R1 accept", 64'(accept_o), 0);
    chk("R1 flags", 64'({filt_fail_o, mcast_o}), 0);
    // R1: zero table hits entry 0
    cmp_check("R1 zero addr", 48'h0, 0, 0, 0, 0);

    // R2, R3: full-size load, every entry hits at its index
    rand_frame();
    do_load(FLEN);
    for (int k = 0; k < N; k++) cmp_check("R3 entry", mt[k], 0, 0, 0, 0);
    // R3: ignored slot bytes do not form an entry
    cmp_check("R3 ignored bytes", frm_addr(4, 2), 0, 0, 0, 0);
    chk("R3 ignored miss", 64'(accept_o), 64'(mt[0] == frm_addr(4, 2)));

    // R2: off-by-one lengths leave the table alone
    a = mt[7];
    rand_frame(); do_load(FLEN - 1);
    cmp_check("R2 len-1 keeps", a, 0, 0, 0, 0);
    rand_frame(); do_load(FLEN + 1);
    cmp_check("R2 len+1 keeps", a, 0, 0, 0, 0);
    chk("R2 kept accept", 64'(accept_o), 1);

    // R4: broadcast under inverse and other modes
    cmp_check("R4 bcast inverse", 48'hFFFF_FFFF_FFFF, 0, 0, 0, 1);
    cmp_check("R4 bcast all modes", 48'hFFFF_FFFF_FFFF, 1, 1, 1, 1);
    // R5
    cmp_check("R5 promisc", 48'h0200_0000_1234, 1, 0, 0, 0);
    cmp_check("R5 rx_all", 48'h0200_0000_5678, 0, 1, 0, 1);
    cmp_check("R5 over multicast", 48'h0100_5E00_0001, 1, 0, 1, 0);
    // R6
    cmp_check("R6 multicast", 48'h0100_5E00_0001, 0, 0, 1, 0);
    cmp_check("R6 unicast no pass", 48'h0000_5E00_0001, 0, 0, 1, 0);
    // R7
    cmp_check("R7 inverse miss", 48'h0A0B_0C0D_0E0F, 0, 0, 0, 1);
    cmp_check("R7 inverse hit", mt[15], 0, 0, 0, 1);

    // R8: request held during a load, judged on new table
    rand_frame();
    a = frm_addr(5, 0);
    early = 0;
    @(negedge clk_i);
    setup_start_i = 1; setup_len_i = LEN_W'(FLEN);
    @(negedge clk_i);
    setup_start_i = 0;
    for (int i = 0; i < FLEN; i++) begin
      setup_valid_i = 1; setup_byte_i = frm[i];
      if (i == 60) begin
        cmp_req_i = 1; cmp_addr_i = a;
        promisc_i = 0; rx_all_i = 0; pass_mcast_i = 0; inverse_i = 0;
      end
      @(negedge clk_i);
      cmp_req_i = 0;
      if (done_o) early = 1;
    end
    setup_valid_i = 0;
    for (int k = 0; k < N; k++) mt[k] = frm_addr(k, 0);
    model(a, 0, 0, 0, 0, e_acc, e_ff, e_mf, e_lat);
    wait_done(n);
    chk("R8 no early done", 64'(early), 0);
    chk("R8 accept new table", 64'(accept_o), 64'(e_acc));
    chk("R8 latency after load", 64'(n), 64'(e_lat + 1));

    // R10: request during scan ignored
    a  = 48'h0012_3456_789A;
    a2 = 48'hFFFF_FFFF_FFFF;
    model(a, 0, 0, 0, 0, e_acc, e_ff, e_mf, e_lat);
    @(negedge clk_i);
    cmp_req_i = 1; cmp_addr_i = a;
    @(posedge clk_i); @(negedge clk_i);
    cmp_req_i = 0;
    n = 0;
    repeat (3) begin @(posedge clk_i); n++; @(negedge clk_i); end
    cmp_req_i = 1; cmp_addr_i = a2;
    @(posedge clk_i); n++; @(negedge clk_i);
    cmp_req_i = 0;
    while (!done_o && n < 60) begin @(posedge clk_i); n++; @(negedge clk_i); end
    chk("R10 first result kept", 64'(accept_o), 64'(e_acc));
    chk("R10 latency", 64'(n), 64'(e_lat));
    early = 0;
    repeat (20) begin @(posedge clk_i); @(negedge clk_i); if (done_o) early = 1; end
    chk("R10 no second done", 64'(early), 0);

    // Random mix (R4 R5 R6 R7 R9)
    for (int it = 0; it < 300; it++) begin
      int sel = $urandom_range(0, 9);
      bit p, ra, pm, inv;
      if (it % 100 == 99) begin rand_frame(); do_load(FLEN); end
      if (sel < 4) a = mt[$urandom_range(0, N - 1)];
      else if (sel == 4) a = 48'hFFFF_FFFF_FFFF;
      else a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      p   = ($urandom_range(0, 7) == 0);
      ra  = ($urandom_range(0, 7) == 0);
      pm  = ($urandom_range(0, 3) == 0);
      inv = ($urandom_range(0, 3) == 0);
      cmp_check("R7 random", a, p, ra, pm, inv);
    end

    ended = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule